// File: doc/BRIEF.md
# Serial Register Programming Interface

This block is a three-wire serial slave that programs a bank of holding registers. A host lowers an active-low frame enable, clocks a 16-bit command word in on SDI (most significant bit first, one bit per rising SCLK edge), and raises the frame enable again. The upper five bits of the word pick a register and the lower eleven bits carry its new code. The write lands only when the frame closes. At that point the target register takes the new code and its update strobe pulses for one system clock.

The bank holds twenty registers. Eighteen hold output-channel codes. One holds the common-voltage code. The last is a configuration register: one data bit picks the refresh clock source, and a five-bit field carries a one-hot bandgap trim choice. The same frame format reads a register back when the read select is high. Once the address bits are complete, the addressed code returns on SDO, most significant bit first.

The serial pins are asynchronous to the system clock. They are resynchronised and edge-detected inside the block, so SCLK must run well below the system clock rate. The register contents go out in parallel to the converters that follow.

Top module: `serial_prog_regs`

## Requirements
- R1: While frame_n is low, each rising SCLK edge shifts SDI into a 16-bit word, most significant bit first. On the rising edge of frame_n, the register selected by word bits 15..11 takes word bits 10..0. Register n occupies reg_bus bits n*11+10..n*11.
- R2: Address 0 to 17 select the output-channel registers, 18 selects the common-voltage register, and 19 selects the configuration register. All of them appear on reg_bus at their address index.
- R3: A register's value changes only when a write frame closes. It never changes while a frame is still open, and every change comes with that register's update strobe.
- R4: A committed write raises upd_strobe[address] for exactly one system clock. No other strobe bit rises.
- R5: If more than 16 SCLK rising edges arrive in one frame, only the last 16 bits shifted in form the word.
- R6: A frame with fewer than 16 SCLK rising edges writes nothing and pulses no strobe.
- R7: A write to an address from 20 to 31 changes no register and pulses no strobe. A read of such an address returns zero.
- R8: With rd_sel high (1 = read, 0 = write) through a frame, no register is written. After the fifth rising SCLK edge, the addressed 11-bit code appears on SDO, most significant bit first. SDO changes after each falling SCLK edge, so rising edges 6 to 16 see data bits 10 down to 0. SDO is 0 outside this window.
- R9: ext_clk_sel follows configuration bit 7 (0 = internal, 1 = external), and bg_trim follows configuration bits 4..0. A configuration write with more than one trim bit set keeps the previous trim field but still updates the other bits.
- R10: SCLK edges while frame_n is high shift nothing and change nothing.
- R11: While rst_n is low, all registers, all strobes, ext_clk_sel, bg_trim and SDO are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the whole block |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| frame_n | input | 1 | Active-low frame enable |
| rd_sel | input | 1 | Frame direction: 0 write, 1 read |
| sdo | output | 1 | Serial readback data |
| reg_bus | output | 220 | All register codes, register n at bits n*11+10..n*11 |
| upd_strobe | output | 20 | One-clock update pulse per register |
| ext_clk_sel | output | 1 | Refresh clock source: 0 internal, 1 external |
| bg_trim | output | 5 | One-hot bandgap trim selection |

## Verification
The bench uses the default parameters: twenty registers of eleven bits, a five-bit address and a two-stage synchroniser. With these values, twelve unused addresses are available to probe the ignore and read-as-zero rules. The configuration register sits at the top index, where the trim filter can be driven with both legal and illegal patterns. The serial clock runs at a half period of ten system clocks. This spacing lets the synchronised edges, the delayed readback bit and the commit latency be sampled at fixed points. Frames of 10, 16 and 20 clocks exercise the short-frame discard and the keep-the-last-sixteen rule.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned CFG_CLK_BIT = 7;
  localparam int unsigned TRIM_W      = 5;

  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic open_edge;
    logic close_edge;
  } sp_evt_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sp_frame.sv
module sp_frame
  import sp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic          frame_s,
  input  logic          rd_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo
);
  localparam int WL = AW + DW;
  localparam int CW = $clog2(WL + 1);

  logic          sclk_d, frame_d;
  logic [WL-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          rd_mode;
  logic [DW-1:0] rd_sh;
  sp_evt_t       ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      frame_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_s;
    end
  end

  always_comb begin
    ev.sclk_rise  = sclk_s & ~sclk_d;
    ev.sclk_fall  = ~sclk_s & sclk_d;
    ev.open_edge  = ~frame_s & frame_d;
    ev.close_edge = frame_s & ~frame_d;
  end

  assign rd_addr = {shreg[AW-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      rd_mode <= 1'b0;
      rd_sh   <= '0;
      sdo     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev.open_edge) begin
        cnt     <= '0;
        rd_mode <= rd_s;
        rd_sh   <= '0;
        sdo     <= 1'b0;
      end else if (ev.close_edge) begin
        sdo <= 1'b0;
        if (cnt == CW'(WL) && !rd_mode) begin
          wr_en   <= 1'b1;
          wr_addr <= shreg[WL-1 -: AW];
          wr_data <= shreg[DW-1:0];
        end
      end else if (!frame_s) begin
        if (ev.sclk_rise) begin
          shreg <= {shreg[WL-2:0], sdi_s};
          if (cnt != CW'(WL)) cnt <= cnt + 1'b1;
          if (rd_mode && cnt == CW'(AW - 1)) rd_sh <= rd_data;
        end else if (ev.sclk_fall && rd_mode) begin
          sdo   <= rd_sh[DW-1];
          rd_sh <= {rd_sh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import sp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 11,
  parameter int NREG = 20,
  parameter int CFG_IDX = NREG - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] reg_bus,
  output logic [NREG-1:0]    upd_strobe
);
  logic [TRIM_W-1:0] new_trim;
  logic              trim_ok;

  assign new_trim = wr_data[TRIM_W-1:0];
  assign trim_ok  = (new_trim & (new_trim - 1'b1)) == '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;
    assign hit = wr_en && (wr_addr == AW'(i));
    assign reg_bus[i*DW +: DW] = q;

    if (i == CFG_IDX) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (hit) q <= {wr_data[DW-1:TRIM_W], trim_ok ? new_trim : q[TRIM_W-1:0]};
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (hit) q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_strobe[i] <= 1'b0;
      else upd_strobe[i] <= hit;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = reg_bus[i*DW +: DW];
  end
endmodule

// File: rtl/serial_prog_regs.sv
module serial_prog_regs
  import sp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 11,
  parameter int NREG = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               frame_n,
  input  logic               rd_sel,
  output logic               sdo,
  output logic [NREG*DW-1:0] reg_bus,
  output logic [NREG-1:0]    upd_strobe,
  output logic               ext_clk_sel,
  output logic [TRIM_W-1:0]  bg_trim
);
  localparam int CFG_IDX = NREG - 1;

  logic [3:0]    sync_out;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  sp_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({sclk, sdi, frame_n, rd_sel}),
    .dout(sync_out)
  );

  sp_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_out[3]), .sdi_s(sync_out[2]),
    .frame_s(sync_out[1]), .rd_s(sync_out[0]),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo)
  );

  sp_bank #(.AW(AW), .DW(DW), .NREG(NREG), .CFG_IDX(CFG_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .reg_bus(reg_bus), .upd_strobe(upd_strobe)
  );

  assign ext_clk_sel = reg_bus[CFG_IDX*DW + CFG_CLK_BIT];
  assign bg_trim     = reg_bus[CFG_IDX*DW +: TRIM_W];
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int DW = 11,
  parameter int NREG = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_n,
  input logic [NREG*DW-1:0] reg_bus,
  input logic [NREG-1:0]    upd_strobe,
  input logic [4:0]         bg_trim
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_strobe)); // R4
  AST_TRIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bg_trim)); // R9
  AST_NO_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (upd_strobe != '0) |-> frame_n); // R1

  for (genvar i = 0; i < NREG; i++) begin : g_chg
    AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_bus[i*DW +: DW] != $past(reg_bus[i*DW +: DW])) |-> upd_strobe[i]); // R3
  end
endmodule

bind serial_prog_regs sp_checker #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
  .reg_bus(reg_bus), .upd_strobe(upd_strobe), .bg_trim(bg_trim)
);

// File: tb/tb_serial_prog_regs.sv
`timescale 1ns/1ps
module tb_serial_prog_regs;
  localparam int DW = 11;
  localparam int NREG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, frame_n = 1'b1, rd_sel = 1'b0;
  logic sdo, ext_clk_sel;
  logic [NREG*DW-1:0] reg_bus;
  logic [NREG-1:0] upd_strobe;
  logic [4:0] bg_trim;

  always #2.5 clk = ~clk;

  serial_prog_regs dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .frame_n(frame_n),
    .rd_sel(rd_sel), .sdo(sdo), .reg_bus(reg_bus), .upd_strobe(upd_strobe),
    .ext_clk_sel(ext_clk_sel), .bg_trim(bg_trim)
  );

  int nchk = 0, nfail = 0, settle = 4;
  logic [DW-1:0] exp_reg [NREG];
  int scnt [NREG];
  int escnt [NREG];
  bit cmp_ok;
  int cmp_bad;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NREG; i++) begin exp_reg[i] = '0; scnt[i] = 0; escnt[i] = 0; end
  endtask

  // per-cycle comparison of registers and strobe counts against the model (R3, R4)
  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < NREG; i++) scnt[i] += int'(upd_strobe[i]);
    if (settle > 0) settle--;
    else if (rst_n) begin
      cmp_ok = 1'b1; cmp_bad = 0;
      for (int i = 0; i < NREG; i++)
        if (reg_bus[i*DW +: DW] !== exp_reg[i] || scnt[i] != escnt[i]) begin cmp_ok = 1'b0; cmp_bad = i; end
      chk(cmp_ok, "R3 per-cycle register/strobe", 32'(reg_bus[cmp_bad*DW +: DW]), 32'(exp_reg[cmp_bad]));
    end
  end

  task automatic xfer(input int n, input logic [31:0] w, input bit rd, output logic [31:0] got);
    logic [15:0] word;
    logic [4:0] a;
    logic [DW-1:0] d;
    got = '0;
    @(negedge clk); rd_sel = rd; sclk = 1'b0;
    repeat (4) @(negedge clk);
    frame_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      sdi = w[k];
      repeat (5) @(negedge clk);
      got = {got[30:0], sdo};
      sclk = 1'b1;
      repeat (10) @(negedge clk);
      sclk = 1'b0;
      repeat (5) @(negedge clk);
    end
    frame_n = 1'b1;
    settle = 12;
    word = w[15:0]; a = word[15:11]; d = word[10:0];
    if (!rd && n >= 16 && a < 5'(NREG)) begin
      if (int'(a) == NREG - 1 && $countones(d[4:0]) > 1) exp_reg[a] = {d[10:5], exp_reg[a][4:0]};
      else exp_reg[a] = d;
      escnt[a]++;
    end
    repeat (14) @(negedge clk);
    rd_sel = 1'b0;
  endtask

  function automatic logic [31:0] wd(input int a, input int d);
    return 32'((a << 11) | (d & 16'h7FF));
  endfunction

  logic [31:0] got;
  int s0;

  initial begin
    clear_model();
    repeat (5) @(negedge clk);
    chk(reg_bus == '0, "R11 reset reg_bus", 32'(reg_bus[31:0]), 0);
    chk(upd_strobe == '0 && sdo == 1'b0, "R11 reset strobe/sdo", {upd_strobe, 11'b0, sdo}, 0);
    chk(bg_trim == 5'd0 && ext_clk_sel == 1'b0, "R11 reset cfg", {bg_trim, ext_clk_sel}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    xfer(16, wd(0, 11'h5A5), 0, got);
    chk(reg_bus[0 +: DW] == 11'h5A5, "R1 ch0 write", reg_bus[0 +: DW], 11'h5A5);
    chk(scnt[0] == 1, "R4 ch0 single strobe", scnt[0], 1);
    xfer(16, wd(17, 11'h7FF), 0, got);
    chk(reg_bus[17*DW +: DW] == 11'h7FF, "R2 ch17 write", reg_bus[17*DW +: DW], 11'h7FF);
    xfer(16, wd(5, 11'h001), 0, got);
    chk(reg_bus[5*DW +: DW] == 11'h001, "R1 ch5 write", reg_bus[5*DW +: DW], 11'h001);
    xfer(16, wd(18, 11'h400), 0, got);
    chk(reg_bus[18*DW +: DW] == 11'h400, "R2 common-voltage write", reg_bus[18*DW +: DW], 11'h400);

    xfer(16, wd(17, 0), 1, got);
    chk(got[15:0] == 16'h07FF, "R8 read ch17", got[15:0], 16'h07FF);
    xfer(16, wd(5, 11'h3FF), 1, got);
    chk(got[15:0] == 16'h0001, "R8 read ch5", got[15:0], 16'h0001);
    chk(reg_bus[5*DW +: DW] == 11'h001, "R8 read does not write", reg_bus[5*DW +: DW], 11'h001);
    xfer(16, wd(0, 0), 1, got);
    chk(got[15:0] == 16'h05A5, "R8 read ch0", got[15:0], 16'h05A5);

    xfer(16, wd(19, 11'h084), 0, got);
    chk(ext_clk_sel == 1'b1 && bg_trim == 5'b00100, "R9 cfg write", {ext_clk_sel, bg_trim}, 6'b100100);
    xfer(16, wd(19, 11'h003), 0, got);
    chk(ext_clk_sel == 1'b0 && bg_trim == 5'b00100, "R9 illegal trim kept", {ext_clk_sel, bg_trim}, 6'b000100);
    xfer(16, wd(19, 11'h010), 0, got);
    chk(bg_trim == 5'b10000, "R9 trim msb", bg_trim, 5'b10000);

    s0 = scnt[3];
    xfer(10, 32'h3FF, 0, got);
    chk(scnt[3] == s0 && reg_bus[3*DW +: DW] == 0, "R6 short frame discarded", scnt[3], s0);

    xfer(20, {12'h0, 4'hF, wd(3, 11'h2AB)} , 0, got);
    chk(reg_bus[3*DW +: DW] == 11'h2AB, "R5 long frame last 16", reg_bus[3*DW +: DW], 11'h2AB);

    xfer(16, wd(22, 11'h155), 0, got);
    chk(upd_strobe == '0, "R7 unused address write", upd_strobe, 0);
    xfer(16, wd(22, 0), 1, got);
    chk(got[15:0] == 16'h0, "R7 unused address read", got[15:0], 0);

    @(negedge clk); sdi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b1; repeat (10) @(negedge clk);
      sclk = 1'b0; repeat (10) @(negedge clk);
    end
    chk(reg_bus[0 +: DW] == 11'h5A5 && scnt[0] == escnt[0], "R10 idle sclk no effect", reg_bus[0 +: DW], 11'h5A5);
    xfer(16, wd(9, 11'h0F0), 0, got);
    chk(reg_bus[9*DW +: DW] == 11'h0F0, "R10 frame after idle sclk", reg_bus[9*DW +: DW], 11'h0F0);

    @(negedge clk); rst_n = 1'b0; clear_model(); settle = 4;
    repeat (3) @(negedge clk);
    chk(reg_bus == '0 && bg_trim == 0, "R11 reset clears", 32'(reg_bus[31:0]), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule